// File: doc/BRIEF.md
# Response Queue Interrupt Moderator

This block holds the completion records of one channel in a small queue and decides when the host gets an interrupt for them. A request sequencer pushes one record per finished request. Each record holds a tag, a status code and a per-request force flag. The host sees the oldest record at the head of the queue and removes it with a pop. One instance serves one channel, so a device with many channels places one copy per channel.

The block limits interrupt storms. A record that lands in an empty queue raises an interrupt. A record that lands behind records that are already waiting raises nothing, because the host will find it when it drains the queue. The force flag on a record can still demand an interrupt for that record, but only while the channel's force-enable configuration bit is set. The interrupt output is a registered pulse one cycle long. If the queue is full and no pop frees a slot in the same cycle, an incoming record is discarded and a sticky overflow flag is set.

Top module: `rspq_irq_moderator`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `rsp_level` is 0, and `rsp_valid`, `irq_pulse` and `rsp_overflow` are all 0.
- R2: A record that is accepted while the queue is empty makes `irq_pulse` 1 in the cycle after the push edge.
- R3: A record that is accepted while the queue holds at least one entry, without an honoured force flag, leaves `irq_pulse` at 0 in the following cycle.
- R4: When `cfg_force_en` is 1, a record that is accepted with `push_force` = 1 makes `irq_pulse` 1 in the following cycle, whatever the queue holds.
- R5: When `cfg_force_en` is 0, `push_force` has no effect: an accepted push into a non-empty queue leaves `irq_pulse` at 0.
- R6: Records leave in arrival order. While `rsp_valid` is 1, `rsp_tag` and `rsp_status` show the oldest record. `rsp_level` counts the stored records, and a pop removes the head.
- R7: A push and a pop in the same cycle while one record is stored leave `rsp_level` at 1 and raise no interrupt.
- R8: A push into a full queue with no pop in the same cycle is discarded. It sets `rsp_overflow`, which stays 1 until reset, and it leaves the stored records and `irq_pulse` unchanged (0).
- R9: A force-honoured push into an empty queue produces one pulse that lasts exactly one cycle.
- R10: `rsp_err` is 1 exactly when `rsp_status` of the head record is non-zero. A status of zero means success.
- R11: A pop while the queue is empty is ignored, and `rsp_level` stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_force_en | input | 1 | Channel setting: honour per-record force flags |
| push_valid | input | 1 | Completion record present this cycle |
| push_tag | input | TAG_W | Request tag of the record |
| push_status | input | STAT_W | Completion status, 0 = success |
| push_force | input | 1 | Request asks for an interrupt regardless of queue state |
| pop_req | input | 1 | Host removes the head record |
| rsp_valid | output | 1 | Queue holds at least one record |
| rsp_tag | output | TAG_W | Tag of the head record |
| rsp_status | output | STAT_W | Status of the head record |
| rsp_err | output | 1 | Head status is non-zero |
| rsp_level | output | $clog2(DEPTH+1) | Number of stored records |
| rsp_overflow | output | 1 | Sticky: a record was discarded |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
Every result of a push or a pop is due one clock edge after the stimulus: the interrupt pulse, the new level, the new head record and the overflow flag all appear after the edge that samples the inputs. The head fields and `rsp_err` then follow from the stored state without any further delay. The bench sets the inputs away from the edge, lets exactly one rising edge pass, and compares every output against a reference queue model that it has already advanced by that same step. The bench then applies the next stimulus, so no result is ever compared against the wrong cycle.

// File: rtl/rspq_pkg.sv
package rspq_pkg;
  // Reason an accepted record requests an interrupt
  typedef enum logic [1:0] {
    IRQ_NONE  = 2'b00,
    IRQ_EDGE  = 2'b01,
    IRQ_FORCE = 2'b10,
    IRQ_BOTH  = 2'b11
  } irq_cause_e;
endpackage

// File: rtl/rspq_store.sv
module rspq_store #(
  parameter  int W     = 12,
  parameter  int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  output logic [W-1:0]     rd_data,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full
);
  localparam bool_pow2 = ((1 << PTR_W) == DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

  generate
    if (bool_pow2) begin : g_wrap_free
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  // storage without reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_nxt;
      if (rd_en) rd_ptr <= rd_nxt;
      case ({wr_en, rd_en})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign rd_data = mem[rd_ptr];
  assign empty   = (level == '0);
  assign full    = (level == LVL_W'(DEPTH));
endmodule

// File: rtl/rspq_admit.sv
module rspq_admit (
  input  logic clk,
  input  logic rst,
  input  logic push_valid,
  input  logic pop_req,
  input  logic q_empty,
  input  logic q_full,
  output logic do_push,
  output logic do_pop,
  output logic overflow
);
  logic dropped;

  // a pop on an empty queue is ignored; a pop frees room for a push in the same cycle
  assign do_pop  = pop_req & ~q_empty;
  assign do_push = push_valid & (~q_full | do_pop);
  assign dropped = push_valid & ~do_push;

  always_ff @(posedge clk) begin
    if (rst)          overflow <= 1'b0;
    else if (dropped) overflow <= 1'b1;
  end
endmodule

// File: rtl/rspq_irq_gen.sv
module rspq_irq_gen
  import rspq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic do_push,
  input  logic q_empty,
  input  logic rec_force,
  input  logic cfg_force_en,
  output logic irq_pulse
);
  irq_cause_e cause;

  always_comb begin
    cause = IRQ_NONE;
    if (do_push) begin
      case ({rec_force & cfg_force_en, q_empty})
        2'b01:   cause = IRQ_EDGE;
        2'b10:   cause = IRQ_FORCE;
        2'b11:   cause = IRQ_BOTH;
        default: cause = IRQ_NONE;
      endcase
    end
  end

  // both causes in one cycle merge into a single pulse
  always_ff @(posedge clk) begin
    if (rst) irq_pulse <= 1'b0;
    else     irq_pulse <= (cause != IRQ_NONE);
  end
endmodule

// File: rtl/rspq_irq_moderator.sv
module rspq_irq_moderator #(
  parameter  int TAG_W  = 8,
  parameter  int STAT_W = 4,
  parameter  int DEPTH  = 8,
  localparam int REC_W  = TAG_W + STAT_W,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_force_en,
  input  logic              push_valid,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic [STAT_W-1:0] push_status,
  input  logic              push_force,
  input  logic              pop_req,
  output logic              rsp_valid,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [STAT_W-1:0] rsp_status,
  output logic              rsp_err,
  output logic [LVL_W-1:0]  rsp_level,
  output logic              rsp_overflow,
  output logic              irq_pulse
);
  logic             q_empty, q_full, do_push, do_pop;
  logic [REC_W-1:0] head;

  rspq_admit admit_i (
    .clk        (clk),
    .rst        (rst),
    .push_valid (push_valid),
    .pop_req    (pop_req),
    .q_empty    (q_empty),
    .q_full     (q_full),
    .do_push    (do_push),
    .do_pop     (do_pop),
    .overflow   (rsp_overflow)
  );

  rspq_store #(.W(REC_W), .DEPTH(DEPTH)) store_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (do_push),
    .wr_data ({push_status, push_tag}),
    .rd_en   (do_pop),
    .rd_data (head),
    .level   (rsp_level),
    .empty   (q_empty),
    .full    (q_full)
  );

  rspq_irq_gen irq_i (
    .clk          (clk),
    .rst          (rst),
    .do_push      (do_push),
    .q_empty      (q_empty),
    .rec_force    (push_force),
    .cfg_force_en (cfg_force_en),
    .irq_pulse    (irq_pulse)
  );

  assign rsp_valid  = ~q_empty;
  assign rsp_tag    = head[TAG_W-1:0];
  assign rsp_status = head[REC_W-1:TAG_W];
  assign rsp_err    = rsp_valid & (rsp_status != '0);
endmodule

// File: rtl/rspq_irq_moderator_chk.sv
module rspq_irq_moderator_chk #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_force_en,
  input logic             push_valid,
  input logic             push_force,
  input logic             pop_req,
  input logic [LVL_W-1:0] rsp_level,
  input logic             rsp_overflow,
  input logic             irq_pulse
);
  // R2
  p_irq_on_edge_r2: assert property (@(posedge clk) disable iff (rst)
    push_valid && rsp_level == '0 |=> irq_pulse);
  // R3, R5
  p_quiet_nonempty_r3: assert property (@(posedge clk) disable iff (rst)
    push_valid && rsp_level != '0 && !(push_force && cfg_force_en) |=> !irq_pulse);
  // R4
  p_force_irq_r4: assert property (@(posedge clk) disable iff (rst)
    push_valid && push_force && cfg_force_en && (rsp_level != LVL_W'(DEPTH) || pop_req) |=> irq_pulse);
  // R7
  p_push_pop_one_r7: assert property (@(posedge clk) disable iff (rst)
    push_valid && pop_req && rsp_level == LVL_W'(1) |=> rsp_level == LVL_W'(1));
  // R8
  p_drop_full_r8: assert property (@(posedge clk) disable iff (rst)
    push_valid && !pop_req && rsp_level == LVL_W'(DEPTH) |=> rsp_overflow && rsp_level == LVL_W'(DEPTH) && !irq_pulse);
  p_sticky_ovf_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_overflow |=> rsp_overflow);
  // R9
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    irq_pulse && !$past(push_valid) |-> 1'b0);
  // R11
  p_empty_pop_r11: assert property (@(posedge clk) disable iff (rst)
    pop_req && !push_valid && rsp_level == '0 |=> rsp_level == '0);
endmodule

bind rspq_irq_moderator rspq_irq_moderator_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .cfg_force_en (cfg_force_en),
  .push_valid   (push_valid),
  .push_force   (push_force),
  .pop_req      (pop_req),
  .rsp_level    (rsp_level),
  .rsp_overflow (rsp_overflow),
  .irq_pulse    (irq_pulse)
);

// File: tb/rspq_irq_moderator_tb_top.sv
`timescale 1ns/1ps
module rspq_irq_moderator_tb_top;
  localparam int TAG_W  = 8;
  localparam int STAT_W = 4;
  localparam int DEPTH  = 8;
  localparam int LVL_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_force_en = 1'b0;
  logic push_valid = 1'b0;
  logic [TAG_W-1:0] push_tag = '0;
  logic [STAT_W-1:0] push_status = '0;
  logic push_force = 1'b0;
  logic pop_req = 1'b0;
  logic rsp_valid, rsp_err, rsp_overflow, irq_pulse;
  logic [TAG_W-1:0] rsp_tag;
  logic [STAT_W-1:0] rsp_status;
  logic [LVL_W-1:0] rsp_level;

  always #4 clk = ~clk;

  rspq_irq_moderator #(.TAG_W(TAG_W), .STAT_W(STAT_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .cfg_force_en(cfg_force_en),
    .push_valid(push_valid), .push_tag(push_tag), .push_status(push_status),
    .push_force(push_force), .pop_req(pop_req),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_status(rsp_status),
    .rsp_err(rsp_err), .rsp_level(rsp_level), .rsp_overflow(rsp_overflow),
    .irq_pulse(irq_pulse)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [TAG_W-1:0]  m_tag [$];
  logic [STAT_W-1:0] m_st  [$];
  bit m_ovf = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string irq_label(bit p, bit f, bit pp, bit cfg, int lvl, bit acc);
    if (p && !acc) return "R8";
    if (p && pp && lvl == 1) return "R7";
    if (acc && lvl == 0) return "R2";
    if (p && f) return cfg ? "R4" : "R5";
    return "R3";
  endfunction

  // apply one cycle of stimulus, advance model, check outputs after the edge
  task automatic step(input bit p, input bit f, input bit pp, input bit cfg,
                      input logic [TAG_W-1:0] tg, input logic [STAT_W-1:0] st);
    int lvl;
    bit dpop, acc, eirq;
    string lbl;
    lvl  = m_tag.size();
    dpop = pp && lvl > 0;
    acc  = p && (lvl < DEPTH || dpop);
    eirq = acc && (lvl == 0 || (f && cfg));
    lbl  = irq_label(p, f, pp, cfg, lvl, acc);
    push_valid = p; push_force = f; pop_req = pp; cfg_force_en = cfg;
    push_tag = tg; push_status = st;
    @(posedge clk); #2;
    if (dpop) begin void'(m_tag.pop_front()); void'(m_st.pop_front()); end
    if (acc) begin m_tag.push_back(tg); m_st.push_back(st); end
    if (p && !acc) m_ovf = 1;
    push_valid = 0; push_force = 0; pop_req = 0;
    chk(lbl, int'(irq_pulse), int'(eirq));
    chk((pp && lvl == 0) ? "R11" : "R6", int'(rsp_level), m_tag.size());
    chk("R8", int'(rsp_overflow), int'(m_ovf));
    chk("R6", int'(rsp_valid), int'(m_tag.size() > 0));
    if (m_tag.size() > 0) begin
      chk("R6", int'(rsp_tag), int'(m_tag[0]));
      chk("R6", int'(rsp_status), int'(m_st[0]));
      chk("R10", int'(rsp_err), int'(m_st[0] != 0));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #2;
    chk("R1", int'(rsp_level), 0);
    chk("R1", int'(irq_pulse), 0);
    rst = 0;
    @(posedge clk); #2;
    chk("R1", int'(rsp_valid), 0);
    chk("R1", int'(rsp_overflow), 0);
    chk("R1", int'(irq_pulse), 0);
    // R11: pop on empty
    step(0, 0, 1, 0, 8'h00, 4'h0);
    // R2, R3, R5, R4
    step(1, 0, 0, 0, 8'hA1, 4'h0);
    step(1, 0, 0, 0, 8'hA2, 4'h3);
    step(1, 1, 0, 0, 8'hA3, 4'h0);
    step(1, 1, 0, 1, 8'hA4, 4'h1);
    // drain, then R7
    repeat (4) step(0, 0, 1, 0, 8'h00, 4'h0);
    step(1, 0, 0, 0, 8'hB1, 4'h2);
    step(1, 0, 1, 0, 8'hB2, 4'h0);
    step(0, 0, 1, 0, 8'h00, 4'h0);
    // R8: fill to full and beyond
    for (int i = 0; i < DEPTH + 2; i++) step(1, 0, 0, 0, 8'(8'hC0 + i), 4'(i));
    step(1, 1, 0, 1, 8'hCF, 4'h0);
    step(1, 0, 1, 0, 8'hCE, 4'h5);
    repeat (DEPTH) step(0, 0, 1, 0, 8'h00, 4'h0);
    // R9: forced push into empty gives one pulse only
    step(1, 1, 0, 1, 8'hD1, 4'h0);
    step(0, 0, 0, 1, 8'h00, 4'h0);
    chk("R9", int'(irq_pulse), 0);
    step(0, 0, 1, 1, 8'h00, 4'h0);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      bit p, f, pp, cfg;
      p   = ($urandom % 100) < 55;
      pp  = ($urandom % 100) < 45;
      f   = ($urandom % 100) < 25;
      cfg = ($urandom % 100) < 50;
      step(p, f, pp, cfg, 8'($urandom), 4'($urandom % 3 == 0 ? $urandom : 0));
    end
    finish_run();
  end
endmodule